// File: doc/BRIEF.md
# Receive Sampling Delay Tuning Controller

This block is a hardware sequencer. It picks the receive-data sampling delay for a card interface. After a start pulse it sweeps a delay line of `NUM_TAPS` taps, from tap 0 upward. Each new tap is applied with the card clock gated off, followed by a settling wait. At each tap the block runs a run of tuning trials through an external trial engine. A tap counts as good only when every trial in its run passes.

Good taps that sit next to each other form windows, and the block keeps the widest one. When the sweep is over it emits one cleanup pulse. It then programs the floor midpoint of the best window and runs a single confirming trial. The result of that trial is reported as the tuning status, together with the chosen tap.

Trial requests leave on a valid/ready pair. `req_valid_o` rises only when a trial is wanted. It then stays high, with no other change, until `req_ready_i` is seen high on a clock edge. Only one trial is outstanding at a time. The engine answers with a one-cycle `rsp_valid_i` strobe that carries `rsp_pass_i`. The block is always ready for that answer, so the response side has no back-pressure. Everything else is plain control and status.

Top module: `rxtune_ctrl`

## Requirements
- R1: After reset, the outputs are as follows: `card_clk_en_o`=1, `rx_dly_o`=0, `lat_1t_o`=1, `tx_src_inv_o`=0, `tx_dly_o`=0, `busy_o`=0, `done_o`=0, `req_valid_o`=0 and `cleanup_o`=0.
- R2: A start pulse while idle begins a sweep at tap 0. During the sweep, each newly applied tap either equals the previous one or is exactly one higher. The only repeat is the retest of the tap that closed a window.
- R3: A tap is applied in three steps. First `card_clk_en_o` drops. Then, while the clock is off, the block writes `rx_dly_o`=tap, `lat_1t_o`=0, `tx_dly_o`=0 and `tx_src_inv_o`=1. Then `card_clk_en_o` returns to 1. `rx_dly_o` never changes while `card_clk_en_o` is 1.
- R4: No trial is requested while the card clock is off. No trial is requested until at least `SETTLE_CYC` cycles after `card_clk_en_o` returns to 1.
- R5: A tap passes only if `TRIALS` trials in a row pass. The first failing response ends the run at that tap, and no further request is made for it.
- R6: Once `req_valid_o` is high it stays high until a cycle in which `req_ready_i` is high. Exactly one response is awaited per accepted request.
- R7: A window runs from its first passing tap to the tap just below the first failure after it. A window still open at the last tap ends at the last tap. A window replaces the stored best only if it is strictly longer, so on a tie the earlier window is kept.
- R8: Exactly one single-cycle `cleanup_o` pulse is issued per tuning run. It comes after the sweep and before the final tap is applied.
- R9: With a best window from S to E, the final tap is floor((S+E)/2). The block runs one trial at that tap, then pulses `done_o` for one cycle. At the same time it sets `tune_pass_o` to the trial result and `chosen_tap_o` to the tap.
- R10: If no tap passes during the sweep, the block applies tap 0 and makes no final trial. It then pulses `done_o` with `tune_pass_o`=0 and `chosen_tap_o`=0.
- R11: A start pulse while `busy_o` is 1 is ignored. The running sweep goes on unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Start pulse that begins a tuning run |
| req_valid_o | output | 1 | Trial request valid |
| req_ready_i | input | 1 | The trial engine accepts the request |
| rsp_valid_i | input | 1 | Trial response strobe |
| rsp_pass_i | input | 1 | Trial result: 1 for pass |
| card_clk_en_o | output | 1 | Card clock enable |
| rx_dly_o | output | 7 | Receive sampling delay tap |
| tx_dly_o | output | 7 | Transmit delay field, written as 0 |
| tx_src_inv_o | output | 1 | Selects the inverted clock as the transmit source |
| lat_1t_o | output | 1 | One-cycle latency option, cleared at each tap write |
| cleanup_o | output | 1 | Pulse that clears the data-available status and resets the command and data paths |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle pulse when a run ends |
| tune_pass_o | output | 1 | Status of the final trial |
| chosen_tap_o | output | 7 | Tap chosen in the last run |

## Verification
Two events can land in the same decision cycle. A passing tap 127 extends the open window, and it also ends the sweep. Maps whose pass run reaches the top tap provoke this case: an all-pass map and a map where only tap 127 passes. The clamped window end is judged through the chosen midpoint.

A stray start pulse can also land in the middle of a busy run. The bench judges it by the total number of trial requests and tap applications. Both must match a model of one uninterrupted sweep.

// File: rtl/rxtune_pkg.sv
package rxtune_pkg;
  typedef enum logic [2:0] {
    CT_IDLE, CT_APPLY, CT_TRIAL, CT_CLEAN, CT_FAPPLY, CT_FTRIAL
  } ctl_state_e;

  typedef enum logic [2:0] {
    WR_IDLE, WR_GATE, WR_UNGATE, WR_SETTLE
  } wr_state_e;

  typedef enum logic [1:0] {
    TR_IDLE, TR_REQ, TR_WAIT
  } tr_state_e;
endpackage

// File: rtl/rxtune_tap_writer.sv
module rxtune_tap_writer
  import rxtune_pkg::*;
#(
  parameter int TAP_W      = 7,
  parameter int TX_W       = 7,
  parameter int SETTLE_CYC = 150000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_i,
  input  logic [TAP_W-1:0] tap_i,
  output logic             card_clk_en_o,
  output logic [TAP_W-1:0] rx_dly_o,
  output logic [TX_W-1:0]  tx_dly_o,
  output logic             tx_src_inv_o,
  output logic             lat_1t_o,
  output logic             settled_o
);
  localparam int CNT_W = $clog2(SETTLE_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYC - 1);

  wr_state_e        st_q;
  logic [TAP_W-1:0] tap_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q          <= WR_IDLE;
      tap_q         <= '0;
      cnt_q         <= '0;
      card_clk_en_o <= 1'b1;
      rx_dly_o      <= '0;
      tx_dly_o      <= '0;
      tx_src_inv_o  <= 1'b0;
      lat_1t_o      <= 1'b1;
      settled_o     <= 1'b0;
    end else begin
      settled_o <= 1'b0;
      case (st_q)
        WR_IDLE: if (go_i) begin
          card_clk_en_o <= 1'b0;
          tap_q         <= tap_i;
          st_q          <= WR_GATE;
        end
        WR_GATE: begin
          lat_1t_o     <= 1'b0;
          rx_dly_o     <= tap_q;
          tx_dly_o     <= '0;
          tx_src_inv_o <= 1'b1;
          st_q         <= WR_UNGATE;
        end
        WR_UNGATE: begin
          card_clk_en_o <= 1'b1;
          cnt_q         <= '0;
          st_q          <= WR_SETTLE;
        end
        WR_SETTLE: begin
          if (cnt_q == CNT_LAST) begin
            settled_o <= 1'b1;
            st_q      <= WR_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: st_q <= WR_IDLE;
      endcase
    end
  end

  // R3: the delay field moves only while the card clock is gated
  assert_gated_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_dly_o != $past(rx_dly_o)) |-> !card_clk_en_o);

  // R4: settling finishes only with the clock running
  assert_settle_clk_on_R4: assert property (@(posedge clk) disable iff (!rst_n)
    settled_o |-> card_clk_en_o);
endmodule

// File: rtl/rxtune_trial_runner.sv
module rxtune_trial_runner
  import rxtune_pkg::*;
#(
  parameter int TRIALS = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go_i,
  input  logic single_i,
  output logic req_valid_o,
  input  logic req_ready_i,
  input  logic rsp_valid_i,
  input  logic rsp_pass_i,
  output logic done_o,
  output logic pass_o
);
  localparam int CNT_W = $clog2(TRIALS + 1);
  localparam logic [CNT_W-1:0] LAST_MULTI = CNT_W'(TRIALS - 1);

  tr_state_e        st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit_q;

  assign req_valid_o = (st_q == TR_REQ);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= TR_IDLE;
      cnt_q   <= '0;
      limit_q <= '0;
      done_o  <= 1'b0;
      pass_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (st_q)
        TR_IDLE: if (go_i) begin
          cnt_q   <= '0;
          limit_q <= single_i ? '0 : LAST_MULTI;
          st_q    <= TR_REQ;
        end
        TR_REQ: if (req_ready_i) st_q <= TR_WAIT;
        TR_WAIT: if (rsp_valid_i) begin
          if (!rsp_pass_i) begin
            done_o <= 1'b1;
            pass_o <= 1'b0;
            st_q   <= TR_IDLE;
          end else if (cnt_q == limit_q) begin
            done_o <= 1'b1;
            pass_o <= 1'b1;
            st_q   <= TR_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
            st_q  <= TR_REQ;
          end
        end
        default: st_q <= TR_IDLE;
      endcase
    end
  end

  // R6: a request is held until the engine takes it
  assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && !req_ready_i) |=> req_valid_o);

  // R5: never more trials than the run length
  assert_trial_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != TR_IDLE) |-> (cnt_q < CNT_W'(TRIALS)));
endmodule

// File: rtl/rxtune_window_tracker.sv
module rxtune_window_tracker #(
  parameter int TAP_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             close_i,
  input  logic [TAP_W-1:0] win_s_i,
  input  logic [TAP_W-1:0] win_e_i,
  output logic             best_valid_o,
  output logic [TAP_W-1:0] best_s_o,
  output logic [TAP_W-1:0] best_e_o,
  output logic [TAP_W-1:0] mid_o
);
  localparam int LEN_W = TAP_W + 1;

  logic [LEN_W-1:0] best_len_q;
  logic [LEN_W-1:0] cand_len;
  logic [LEN_W-1:0] mid_sum;

  assign cand_len     = LEN_W'(win_e_i) - LEN_W'(win_s_i) + 1'b1;
  assign mid_sum      = LEN_W'(best_s_o) + LEN_W'(best_e_o);
  assign mid_o        = mid_sum[LEN_W-1:1];
  assign best_valid_o = (best_len_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n || clear_i) begin
      best_len_q <= '0;
      best_s_o   <= '0;
      best_e_o   <= '0;
    end else if (close_i && (cand_len > best_len_q)) begin
      best_len_q <= cand_len;
      best_s_o   <= win_s_i;
      best_e_o   <= win_e_i;
    end
  end

  // R7: the stored best never shrinks within a run
  assert_best_grows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!clear_i) |-> (best_len_q >= $past(best_len_q)));

  // R9: midpoint lies within the best window
  assert_mid_inside_R9: assert property (@(posedge clk) disable iff (!rst_n)
    best_valid_o |-> (mid_o >= best_s_o && mid_o <= best_e_o));
endmodule

// File: rtl/rxtune_ctrl.sv
module rxtune_ctrl
  import rxtune_pkg::*;
#(
  parameter int NUM_TAPS   = 128,
  parameter int TRIALS     = 50,
  parameter int SETTLE_CYC = 150000,
  parameter int TX_W       = 7
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start_i,
  output logic                        req_valid_o,
  input  logic                        req_ready_i,
  input  logic                        rsp_valid_i,
  input  logic                        rsp_pass_i,
  output logic                        card_clk_en_o,
  output logic [$clog2(NUM_TAPS)-1:0] rx_dly_o,
  output logic [TX_W-1:0]             tx_dly_o,
  output logic                        tx_src_inv_o,
  output logic                        lat_1t_o,
  output logic                        cleanup_o,
  output logic                        busy_o,
  output logic                        done_o,
  output logic                        tune_pass_o,
  output logic [$clog2(NUM_TAPS)-1:0] chosen_tap_o
);
  localparam int TAP_W = $clog2(NUM_TAPS);
  localparam logic [TAP_W-1:0] MAX_TAP = TAP_W'(NUM_TAPS - 1);

  ctl_state_e       st_q, st_d;
  logic [TAP_W-1:0] tap_q, tap_d;
  logic [TAP_W-1:0] ws_q, ws_d;
  logic             seek_end_q, seek_end_d;

  logic             w_go, w_settled;
  logic [TAP_W-1:0] w_tap;
  logic             r_go, r_single, r_done, r_pass;
  logic             t_clear, t_close;
  logic [TAP_W-1:0] t_s, t_e;
  logic             best_valid;
  logic [TAP_W-1:0] best_s, best_e, best_mid;
  logic             fin, fin_pass;
  logic [TAP_W-1:0] fin_tap;
  logic             last_tap;

  rxtune_tap_writer #(.TAP_W(TAP_W), .TX_W(TX_W), .SETTLE_CYC(SETTLE_CYC)) u_writer (
    .clk(clk), .rst_n(rst_n), .go_i(w_go), .tap_i(w_tap),
    .card_clk_en_o(card_clk_en_o), .rx_dly_o(rx_dly_o), .tx_dly_o(tx_dly_o),
    .tx_src_inv_o(tx_src_inv_o), .lat_1t_o(lat_1t_o), .settled_o(w_settled)
  );

  rxtune_trial_runner #(.TRIALS(TRIALS)) u_runner (
    .clk(clk), .rst_n(rst_n), .go_i(r_go), .single_i(r_single),
    .req_valid_o(req_valid_o), .req_ready_i(req_ready_i),
    .rsp_valid_i(rsp_valid_i), .rsp_pass_i(rsp_pass_i),
    .done_o(r_done), .pass_o(r_pass)
  );

  rxtune_window_tracker #(.TAP_W(TAP_W)) u_tracker (
    .clk(clk), .rst_n(rst_n), .clear_i(t_clear), .close_i(t_close),
    .win_s_i(t_s), .win_e_i(t_e), .best_valid_o(best_valid),
    .best_s_o(best_s), .best_e_o(best_e), .mid_o(best_mid)
  );

  assign last_tap  = (tap_q == MAX_TAP);
  assign busy_o    = (st_q != CT_IDLE);
  assign cleanup_o = (st_q == CT_CLEAN);

  always_comb begin
    st_d       = st_q;
    tap_d      = tap_q;
    ws_d       = ws_q;
    seek_end_d = seek_end_q;
    w_go       = 1'b0;
    w_tap      = tap_q;
    r_go       = 1'b0;
    r_single   = 1'b0;
    t_clear    = 1'b0;
    t_close    = 1'b0;
    t_s        = ws_q;
    t_e        = tap_q;
    fin        = 1'b0;
    fin_pass   = 1'b0;
    fin_tap    = '0;
    case (st_q)
      CT_IDLE: if (start_i) begin
        t_clear    = 1'b1;
        tap_d      = '0;
        seek_end_d = 1'b0;
        w_go       = 1'b1;
        w_tap      = '0;
        st_d       = CT_APPLY;
      end
      CT_APPLY: if (w_settled) begin
        r_go = 1'b1;
        st_d = CT_TRIAL;
      end
      CT_TRIAL: if (r_done) begin
        if (!seek_end_q) begin
          if (r_pass) ws_d = tap_q;
          if (last_tap) begin
            t_close = r_pass;
            t_s     = tap_q;
            t_e     = tap_q;
            st_d    = CT_CLEAN;
          end else begin
            seek_end_d = r_pass;
            tap_d      = tap_q + 1'b1;
            w_go       = 1'b1;
            w_tap      = tap_q + 1'b1;
            st_d       = CT_APPLY;
          end
        end else if (r_pass) begin
          if (last_tap) begin
            t_close = 1'b1;
            t_e     = MAX_TAP;
            st_d    = CT_CLEAN;
          end else begin
            tap_d = tap_q + 1'b1;
            w_go  = 1'b1;
            w_tap = tap_q + 1'b1;
            st_d  = CT_APPLY;
          end
        end else begin
          t_close    = 1'b1;
          t_e        = tap_q - 1'b1;
          seek_end_d = 1'b0;
          w_go       = 1'b1;
          w_tap      = tap_q;
          st_d       = CT_APPLY;
        end
      end
      CT_CLEAN: begin
        w_go  = 1'b1;
        w_tap = best_valid ? best_mid : '0;
        st_d  = CT_FAPPLY;
      end
      CT_FAPPLY: if (w_settled) begin
        if (best_valid) begin
          r_go     = 1'b1;
          r_single = 1'b1;
          st_d     = CT_FTRIAL;
        end else begin
          fin  = 1'b1;
          st_d = CT_IDLE;
        end
      end
      CT_FTRIAL: if (r_done) begin
        fin      = 1'b1;
        fin_pass = r_pass;
        fin_tap  = best_mid;
        st_d     = CT_IDLE;
      end
      default: st_d = CT_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q         <= CT_IDLE;
      tap_q        <= '0;
      ws_q         <= '0;
      seek_end_q   <= 1'b0;
      done_o       <= 1'b0;
      tune_pass_o  <= 1'b0;
      chosen_tap_o <= '0;
    end else begin
      st_q       <= st_d;
      tap_q      <= tap_d;
      ws_q       <= ws_d;
      seek_end_q <= seek_end_d;
      done_o     <= fin;
      if (fin) begin
        tune_pass_o  <= fin_pass;
        chosen_tap_o <= fin_tap;
      end
    end
  end

  // R4: trials only run with the card clock on
  assert_req_clk_on_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o |-> card_clk_en_o);

  // R8: cleanup is a single-cycle pulse
  assert_cleanup_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cleanup_o |=> !cleanup_o);

  // R9: done is a single-cycle pulse
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R10: a failed run with no window reports tap 0
  assert_nopass_tap0_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !tune_pass_o && !best_valid) |-> (chosen_tap_o == '0 && rx_dly_o == '0));

  // R11: a start while busy leaves the run going
  assert_busy_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !fin) |=> busy_o);
endmodule

// File: tb/rxtune_ctrl_tb.sv
module rxtune_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NT     = 128;
  localparam int NTRIAL = 50;
  localparam int SETTLE = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic req_ready_i = 1'b0;
  logic rsp_valid_i = 1'b0;
  logic rsp_pass_i = 1'b0;
  logic req_valid_o, card_clk_en_o, tx_src_inv_o, lat_1t_o, cleanup_o;
  logic busy_o, done_o, tune_pass_o;
  logic [6:0] rx_dly_o, tx_dly_o, chosen_tap_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  rxtune_ctrl #(.NUM_TAPS(NT), .TRIALS(NTRIAL), .SETTLE_CYC(SETTLE), .TX_W(7)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .req_valid_o(req_valid_o), .req_ready_i(req_ready_i),
    .rsp_valid_i(rsp_valid_i), .rsp_pass_i(rsp_pass_i),
    .card_clk_en_o(card_clk_en_o), .rx_dly_o(rx_dly_o), .tx_dly_o(tx_dly_o),
    .tx_src_inv_o(tx_src_inv_o), .lat_1t_o(lat_1t_o), .cleanup_o(cleanup_o),
    .busy_o(busy_o), .done_o(done_o), .tune_pass_o(tune_pass_o),
    .chosen_tap_o(chosen_tap_o)
  );

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;

  logic [NT-1:0] pmap, fmap;
  bit fail_final = 0;
  bit post_clean = 0;
  int trial_idx = 0;
  bit hs_pend = 0;
  int rsp_wait = -1;
  bit rsp_res = 0;
  int nreq = 0, napp = 0, nclean = 0;
  int v_gate = 0, v_fields = 0, v_settle = 0, v_seq = 0;
  int since_en = 0;
  int last_tap = -1;
  logic prev_en = 1'b1;
  logic [6:0] prev_rx = '0;

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // engine and monitors, all at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (cyc > 190000) begin
        n_fail++;
        n_checks++;
        $display("FAIL R9 watchdog actual=%0d expected=%0d", cyc, 190000);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
      end
      if (!card_clk_en_o) trial_idx = 0;
      if (cleanup_o) begin post_clean = 1; nclean++; end
      if (rx_dly_o != prev_rx && card_clk_en_o) v_gate++;
      if (card_clk_en_o && !prev_en) begin
        napp++;
        since_en = 0;
        if (lat_1t_o !== 1'b0 || tx_dly_o !== 7'd0 || tx_src_inv_o !== 1'b1) v_fields++;
        if (!post_clean) begin
          if (last_tap < 0) begin
            if (rx_dly_o != 0) v_seq++;
          end else if (!(int'(rx_dly_o) == last_tap || int'(rx_dly_o) == last_tap + 1)) v_seq++;
          last_tap = int'(rx_dly_o);
        end
      end else begin
        since_en++;
      end
      if (req_valid_o && (!card_clk_en_o || since_en < SETTLE)) v_settle++;
      prev_en = card_clk_en_o;
      prev_rx = rx_dly_o;
      // trial engine
      if (rsp_valid_i) rsp_valid_i = 1'b0;
      if (hs_pend) begin
        hs_pend = 0;
        req_ready_i = 1'b0;
        nreq++;
        if (fail_final && post_clean) rsp_res = 1'b0;
        else rsp_res = pmap[rx_dly_o] && !(fmap[rx_dly_o] && trial_idx == NTRIAL - 1);
        trial_idx++;
        rsp_wait = int'($urandom % 2);
      end
      if (rsp_wait == 0) begin
        rsp_valid_i = 1'b1;
        rsp_pass_i = rsp_res;
        rsp_wait = -1;
      end else if (rsp_wait > 0) begin
        rsp_wait--;
      end else if (req_valid_o && !rsp_valid_i && !req_ready_i) begin
        if ($urandom % 4 != 0) begin
          req_ready_i = 1'b1;
          hs_pend = 1;
        end
      end
    end
  end

  // model of one tuning run from the requirements
  task automatic model(input logic [NT-1:0] pm, input logic [NT-1:0] fm,
                       output bit found, output int bs, output int be,
                       output int ereq, output int eapp);
    int t, ws, bl;
    bit seek, p;
    t = 0; ws = 0; bl = 0; seek = 0; ereq = 0; eapp = 0; bs = 0; be = 0;
    forever begin
      eapp++;
      if (!pm[t]) begin ereq += 1; p = 0; end
      else if (fm[t]) begin ereq += NTRIAL; p = 0; end
      else begin ereq += NTRIAL; p = 1; end
      if (!seek) begin
        if (p) begin
          ws = t;
          if (t == NT - 1) begin
            if (1 > bl) begin bl = 1; bs = t; be = t; end
            break;
          end
          t++; seek = 1;
        end else begin
          if (t == NT - 1) break;
          t++;
        end
      end else if (p) begin
        if (t == NT - 1) begin
          if (NT - ws > bl) begin bl = NT - ws; bs = ws; be = NT - 1; end
          break;
        end
        t++;
      end else begin
        if (t - ws > bl) begin bl = t - ws; bs = ws; be = t - 1; end
        seek = 0;
      end
    end
    eapp++;
    found = (bl > 0);
    if (found) ereq++;
  endtask

  task automatic run(input string name, input logic [NT-1:0] pm, input logic [NT-1:0] fm,
                     input bit ffin, input bit poke);
    bit found; int bs, be, ereq, eapp, etap, k; bit got;
    model(pm, fm, found, bs, be, ereq, eapp);
    etap = found ? (bs + be) / 2 : 0;
    pmap = pm; fmap = fm; fail_final = ffin; post_clean = 0;
    nreq = 0; napp = 0; nclean = 0; v_gate = 0; v_fields = 0; v_settle = 0; v_seq = 0;
    last_tap = -1;
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    check({name, " R2 busy after start"}, int'(busy_o), 1);
    got = 0; k = 0;
    while (k < 60000 && !got) begin
      @(negedge clk);
      k++;
      if (poke && k == 400) start_i = 1'b1;
      else start_i = 1'b0;
      if (done_o) got = 1;
    end
    start_i = 1'b0;
    check({name, " R9 done seen"}, int'(got), 1);
    check({name, " R9 chosen tap"}, int'(chosen_tap_o), etap);
    check({name, " R9 status"}, int'(tune_pass_o), int'(found && !ffin));
    check({name, " R10 final rx tap"}, int'(rx_dly_o), etap);
    check({name, " R5 request count"}, nreq, ereq);
    check({name, " R11 apply count"}, napp, eapp);
    check({name, " R8 cleanup count"}, nclean, 1);
    check({name, " R3 gated write"}, v_gate + v_fields, 0);
    check({name, " R4 settle"}, v_settle, 0);
    check({name, " R2 sweep order"}, v_seq, 0);
    @(negedge clk);
    check({name, " R9 done one cycle"}, int'(done_o), 0);
    check({name, " R7 idle after"}, int'(busy_o), 0);
  endtask

  function automatic logic [NT-1:0] span(input int s, input int e);
    logic [NT-1:0] m = '0;
    for (int i = s; i <= e; i++) m[i] = 1'b1;
    return m;
  endfunction

  initial begin
    logic [NT-1:0] rm;
    void'($urandom(32'd20240420));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 clk en", int'(card_clk_en_o), 1);
    check("R1 rx tap", int'(rx_dly_o), 0);
    check("R1 latency option", int'(lat_1t_o), 1);
    check("R1 tx src", int'(tx_src_inv_o), 0);
    check("R1 idle", int'(busy_o | done_o | req_valid_o | cleanup_o), 0);

    run("allpass_clamp", {NT{1'b1}}, '0, 0, 0);           // R7 clamp at 127
    run("nopass", '0, '0, 0, 0);                          // R10
    run("tie_keep_first", span(10, 19) | span(40, 49), '0, 0, 0); // R7 tie
    rm = span(5, 8) | span(20, 40);
    run("flaky_split", rm, span(25, 25), 0, 1);           // R5 and R11
    run("only_top", span(127, 127), '0, 0, 0);            // R7 clamp single
    run("final_fail", span(60, 70), '0, 1, 0);            // R9 status
    run("flaky_last", span(0, 3), span(0, 0), 0, 0);      // R5 trial 50 fails
    for (int r = 0; r < 3; r++) begin
      bit cur;
      rm = '0;
      cur = 0;
      for (int i = 0; i < NT; i++) begin
        if ($urandom % 6 == 0) cur = ~cur;
        rm[i] = cur;
      end
      run("random", rm, '0, 0, 0);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule